// File: doc/BRIEF.md
# Half-Bridge Fault Supervisor

This block is the digital core of a triple half-bridge driver. It keeps a committed 16-bit control word and drives enable lines for three legs. Each leg has one low-side switch and one high-side switch. The block filters the raw fault comparators through cycle-count qualifiers. It also keeps sticky diagnostic flags and presents a 16-bit status word. A serial front end, which is not part of this block, hands over each complete word with a one-cycle strobe, and it shifts the status word back out.

The block handles each fault class in its own way. Undervoltage forces every switch off while it lasts, and the switches recover by themselves. Overcurrent either latches the offending switch off or only raises a flag, depending on a control bit. Thermal shutdown holds everything off until the die has cooled and software has written a status reset. Every enable change passes through a per-leg interlock, so the two switches of one leg are never on together and a dead gap always separates them.

Top module: `hb_fault_supervisor`

## Requirements
- R1: On a cycle with `ctl_load_i` high, the control word is taken. Bit 0 is a one-shot status reset. Bits 1..6 request LS1, HS1, LS2, HS2, LS3, HS3 (1 = on), which map to `sw_en_o[0..5]`. Bit 13 enables overcurrent shutdown. All other bits are ignored.
- R2: The status word is laid out as follows: bit 0 is the registered temperature warning, bits 1..6 are the actual switch enables in the R1 order, bit 13 is short circuit, bit 14 is open load and bit 15 is supply fail. All other bits read 0.
- R3: If a word requests both switches of one leg, both switches of that leg stay off and no flag is raised. The two enables of a leg are never high together.
- R4: A switch turns off one cycle after its request goes away. A switch turns on only after both switches of its leg have been off for at least DEAD_CYC cycles. Swapping LS1 for HS1 with one load therefore shows HS1 on exactly DEAD_CYC+3 samples after the load.
- R5: A raw fault counts as qualified only after it has stayed high for the number of consecutive cycles set by its delay parameter. A single low cycle restarts the count.
- R6: A qualified undervoltage sets supply fail (bit 15) and forces all switches off. The switches come back when the undervoltage ends, and the flag stays set until a status reset.
- R7: Open load on a switch that is on, once qualified, sets bit 14, which stays set until a status reset. An open-load input on a switch that is off has no effect.
- R8: With overcurrent shutdown enabled, a qualified overcurrent on a switch that is on turns that switch off and sets bit 13. The switch stays off until a status reset.
- R9: With overcurrent shutdown disabled, a qualified overcurrent sets bit 13 and leaves the switches as they are.
- R10: A status reset clears bits 13..15 and releases switches latched off by overcurrent. It does not clear the switch bits 1..6. A flag whose set condition holds in the same cycle as the reset stays set.
- R11: The temperature warning bit follows its comparator one cycle later and is not latched.
- R12: Thermal shutdown forces all switches off. They return only after a status reset written while the shutdown comparator is low.
- R13: While `run_i` is low, or while reset is asserted, all switches are off and the status word reads 0. On leaving that state, the control word holds its default: no switch requested and overcurrent shutdown enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | High for normal operation, low for standby |
| ctl_word_i | input | 16 | Committed control word |
| ctl_load_i | input | 1 | One-cycle strobe that takes `ctl_word_i` |
| uv_raw_i | input | 1 | Raw supply undervoltage comparator |
| oc_raw_i | input | 6 | Raw per-switch overcurrent comparators |
| ol_raw_i | input | 6 | Raw per-switch open-load comparators |
| warn_raw_i | input | 1 | Temperature prewarning comparator |
| tsd_raw_i | input | 1 | Thermal shutdown comparator |
| sw_en_o | output | 6 | Switch enables LS1, HS1, LS2, HS2, LS3, HS3 |
| status_o | output | 16 | Status word |

## Verification
The status reset and a qualified fault can land in the same cycle. In that case the flag must survive, because its set condition wins over the clear. The bench provokes this by holding undervoltage until supply fail is qualified, then loading a word with the reset bit set while the comparator stays high, and then checking that bit 15 still reads 1. It then removes the undervoltage and resets again, and checks that the flag clears while the switch bit it carried through stays set. Random control words are checked against a bench function that applies the leg-conflict rule, and a monitor measures the off gap before every switch turn-on.

// File: rtl/hb_sup_pkg.sv
package hb_sup_pkg;
  localparam int NUM_LEGS = 3;
  localparam int NUM_SW   = 2 * NUM_LEGS;
  localparam int WORD_W   = 16;
  localparam int CTL_SRR    = 0;
  localparam int CTL_SW_LSB = 1;
  localparam int CTL_OCS    = 13;
  localparam int ST_WARN    = 0;
  localparam int ST_SW_LSB  = 1;
  localparam int ST_SC      = 13;
  localparam int ST_OL      = 14;
  localparam int ST_PSF     = 15;
  localparam logic [WORD_W-1:0] CTL_DEFAULT = WORD_W'(1) << CTL_OCS;
endpackage

// File: rtl/hb_fault_qual.sv
module hb_fault_qual #(
  parameter int DLY = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic raw_i,
  output logic qual_o
);
  localparam int CW = $clog2(DLY + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || !raw_i)  cnt_q <= '0;
    else if (cnt_q != CW'(DLY)) cnt_q <= cnt_q + 1'b1;
  end

  assign qual_o = raw_i && !clr_i && (cnt_q == CW'(DLY));

  // qualified level needs the raw input already present the cycle before
  assert_qual_needs_history_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(qual_o) |-> $past(raw_i));
endmodule

// File: rtl/hb_leg_interlock.sv
module hb_leg_interlock #(
  parameter int DEAD = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic want_lo_i,
  input  logic want_hi_i,
  output logic en_lo_o,
  output logic en_hi_o
);
  localparam int GW = $clog2(DEAD + 1);
  logic [GW-1:0] gap_q;
  logic en_lo_q, en_hi_q, gap_ok, lo_d, hi_d;

  assign gap_ok = (gap_q == GW'(DEAD));
  assign lo_d = want_lo_i && !want_hi_i && (en_lo_q || (!en_hi_q && gap_ok));
  assign hi_d = want_hi_i && !want_lo_i && (en_hi_q || (!en_lo_q && gap_ok));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_lo_q <= 1'b0;
      en_hi_q <= 1'b0;
      gap_q   <= '0;
    end else if (clr_i) begin
      en_lo_q <= 1'b0;
      en_hi_q <= 1'b0;
      gap_q   <= '0;
    end else begin
      en_lo_q <= lo_d;
      en_hi_q <= hi_d;
      if (en_lo_q || en_hi_q)     gap_q <= '0;
      else if (!gap_ok)           gap_q <= gap_q + 1'b1;
    end
  end

  assign en_lo_o = en_lo_q;
  assign en_hi_o = en_hi_q;

  assert_leg_exclusive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_lo_q && en_hi_q));
  assert_dead_lo_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_lo_q) |-> $past(!en_hi_q));
  assert_dead_hi_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_hi_q) |-> $past(!en_lo_q));
endmodule

// File: rtl/hb_fault_supervisor.sv
module hb_fault_supervisor
  import hb_sup_pkg::*;
#(
  parameter int UV_DLY   = 8,
  parameter int OC_DLY   = 6,
  parameter int OL_DLY   = 12,
  parameter int DEAD_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [WORD_W-1:0] ctl_word_i,
  input  logic              ctl_load_i,
  input  logic              uv_raw_i,
  input  logic [NUM_SW-1:0] oc_raw_i,
  input  logic [NUM_SW-1:0] ol_raw_i,
  input  logic              warn_raw_i,
  input  logic              tsd_raw_i,
  output logic [NUM_SW-1:0] sw_en_o,
  output logic [WORD_W-1:0] status_o
);
  logic              standby, srr, uv_q, all_ok;
  logic [NUM_SW-1:0] sw_req_q, oc_off_q, oc_q, ol_q, want, sw_en;
  logic              ocs_q, sc_q, ol_flag_q, psf_q, tsd_lat_q, warn_q;
  logic              unused_ctl;

  assign standby    = !run_i;
  assign srr        = run_i && ctl_load_i && ctl_word_i[CTL_SRR];
  assign unused_ctl = ^{ctl_word_i[WORD_W-1:CTL_OCS+1], ctl_word_i[CTL_OCS-1:CTL_SW_LSB+NUM_SW]};

  // control register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || standby) begin
      sw_req_q <= CTL_DEFAULT[CTL_SW_LSB +: NUM_SW];
      ocs_q    <= CTL_DEFAULT[CTL_OCS];
    end else if (ctl_load_i) begin
      sw_req_q <= ctl_word_i[CTL_SW_LSB +: NUM_SW];
      ocs_q    <= ctl_word_i[CTL_OCS];
    end
  end

  hb_fault_qual #(.DLY(UV_DLY)) u_uv_qual (
    .clk_i, .rst_ni, .clr_i(standby), .raw_i(uv_raw_i), .qual_o(uv_q));

  assign all_ok = !uv_q && !tsd_lat_q;

  for (genvar i = 0; i < NUM_SW; i++) begin : g_sw
    hb_fault_qual #(.DLY(OC_DLY)) u_oc_qual (
      .clk_i, .rst_ni, .clr_i(standby), .raw_i(oc_raw_i[i] && sw_en[i]), .qual_o(oc_q[i]));
    hb_fault_qual #(.DLY(OL_DLY)) u_ol_qual (
      .clk_i, .rst_ni, .clr_i(standby), .raw_i(ol_raw_i[i] && sw_en[i]), .qual_o(ol_q[i]));

    // set wins over status reset
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni || standby)   oc_off_q[i] <= 1'b0;
      else if (oc_q[i] && ocs_q) oc_off_q[i] <= 1'b1;
      else if (srr)              oc_off_q[i] <= 1'b0;
    end

    assert_oc_latch_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      oc_off_q[i] |=> !sw_en_o[i]);
  end

  for (genvar l = 0; l < NUM_LEGS; l++) begin : g_leg
    logic req_lo, req_hi;
    assign req_lo = sw_req_q[2*l];
    assign req_hi = sw_req_q[2*l+1];
    // conflicting request: both off, no fault
    assign want[2*l]   = req_lo && !req_hi && !oc_off_q[2*l]   && all_ok;
    assign want[2*l+1] = req_hi && !req_lo && !oc_off_q[2*l+1] && all_ok;

    hb_leg_interlock #(.DEAD(DEAD_CYC)) u_leg (
      .clk_i, .rst_ni, .clr_i(standby),
      .want_lo_i(want[2*l]), .want_hi_i(want[2*l+1]),
      .en_lo_o(sw_en[2*l]), .en_hi_o(sw_en[2*l+1]));
  end

  // sticky diagnostics
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || standby) begin
      sc_q      <= 1'b0;
      ol_flag_q <= 1'b0;
      psf_q     <= 1'b0;
      tsd_lat_q <= 1'b0;
      warn_q    <= 1'b0;
    end else begin
      warn_q <= warn_raw_i;
      if (|oc_q)                    sc_q <= 1'b1;
      else if (srr)                 sc_q <= 1'b0;
      if (|ol_q)                    ol_flag_q <= 1'b1;
      else if (srr)                 ol_flag_q <= 1'b0;
      if (uv_q)                     psf_q <= 1'b1;
      else if (srr)                 psf_q <= 1'b0;
      if (tsd_raw_i)                tsd_lat_q <= 1'b1;
      else if (srr)                 tsd_lat_q <= 1'b0;
    end
  end

  always_comb begin
    status_o = '0;
    status_o[ST_WARN]             = warn_q;
    status_o[ST_SW_LSB +: NUM_SW] = sw_en;
    status_o[ST_SC]               = sc_q;
    status_o[ST_OL]               = ol_flag_q;
    status_o[ST_PSF]              = psf_q;
  end

  assign sw_en_o = sw_en;

  assert_uv_all_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_q |=> (sw_en_o == '0));
  assert_psf_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psf_q && run_i && !srr) |=> psf_q);
  assert_ocs_off_no_latch_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ocs_q && oc_off_q == '0) |=> (oc_off_q == '0));
  assert_tsd_all_off_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tsd_lat_q |=> (sw_en_o == '0));
  assert_standby_clear_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (status_o == '0));
endmodule

// File: tb/hb_fault_supervisor_test.sv
module hb_fault_supervisor_test;
  localparam int UV_DLY = 8, OC_DLY = 6, OL_DLY = 12, DEAD_CYC = 4;

  logic        clk = 1'b0, rst_ni = 1'b0, run_i = 1'b1, ctl_load_i = 1'b0;
  logic [15:0] ctl_word_i = '0;
  logic        uv_raw_i = 1'b0, warn_raw_i = 1'b0, tsd_raw_i = 1'b0;
  logic [5:0]  oc_raw_i = '0, ol_raw_i = '0;
  logic [5:0]  sw_en_o;
  logic [15:0] status_o;
  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hb_fault_supervisor #(.UV_DLY(UV_DLY), .OC_DLY(OC_DLY), .OL_DLY(OL_DLY), .DEAD_CYC(DEAD_CYC)) uut (
    .clk_i(clk), .rst_ni, .run_i, .ctl_word_i, .ctl_load_i, .uv_raw_i, .oc_raw_i,
    .ol_raw_i, .warn_raw_i, .tsd_raw_i, .sw_en_o, .status_o);

  function automatic logic [5:0] exp_en(logic [15:0] w);
    logic [5:0] e = '0;
    for (int l = 0; l < 3; l++)
      if (w[1+2*l] ^ w[2+2*l]) begin
        e[2*l] = w[1+2*l];
        e[2*l+1] = w[2+2*l];
      end
    return e;
  endfunction

  function automatic logic [15:0] exp_st(logic [5:0] en, logic w, logic sc, logic ol, logic psf);
    return {psf, ol, sc, 6'b0, en, w};
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(logic [15:0] w);
    ctl_word_i = w; ctl_load_i = 1'b1;
    step(1);
    ctl_load_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // R4 monitor: off gap before every turn-on, never both on
  int off_cnt [3] = '{0, 0, 0};
  logic [5:0] prev_en = '0;
  always @(negedge clk) begin
    cyc++;
    for (int l = 0; l < 3; l++) begin
      if ((sw_en_o[2*l] && !prev_en[2*l]) || (sw_en_o[2*l+1] && !prev_en[2*l+1])) begin
        n_chk++;
        if (off_cnt[l] < DEAD_CYC) begin
          n_err++;
          $display("FAIL R4 leg%0d gap actual=%0d expected>=%0d", l, off_cnt[l], DEAD_CYC);
        end
      end
      if (sw_en_o[2*l] && sw_en_o[2*l+1]) begin
        n_err++;
        $display("FAIL R3 leg%0d both on actual=11 expected=not 11", l);
      end
      off_cnt[l] = (sw_en_o[2*l] || sw_en_o[2*l+1]) ? 0 : off_cnt[l] + 1;
    end
    prev_en = sw_en_o;
    if (cyc > 100000 && !done) begin
      n_err++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      finish_run();
    end
  end

  initial begin
    logic [15:0] w;
    int c;
    void'($urandom(32'd4242));
    step(5);
    chk("R13 reset status", status_o, 16'h0000);
    chk("R13 reset enables", {10'b0, sw_en_o}, 16'h0000);
    rst_ni = 1'b1;
    step(3);

    // R1 R2 R3 random words, no faults
    for (int k = 0; k < 40; k++) begin
      w = 16'($urandom);
      if (k < 4) w = 16'h2000 | (16'h6 << (2*k % 6)); // leg conflicts
      load(w);
      step(20);
      chk("R1 R3 enables", {10'b0, sw_en_o}, {10'b0, exp_en(w)});
      chk("R2 status", status_o, exp_st(exp_en(w), 1'b0, 1'b0, 1'b0, 1'b0));
    end

    // R4 swap latency
    load(16'h2002); step(20);
    load(16'h2004);
    c = 1;
    while (!sw_en_o[1] && c < 50) begin step(1); c++; end
    chk("R4 swap latency", 16'(c), 16'(DEAD_CYC + 3));
    chk("R4 low side off", {15'b0, sw_en_o[0]}, 16'h0);

    // R5 R6 undervoltage
    load(16'h2002); step(20);
    uv_raw_i = 1'b1; step(UV_DLY - 1); uv_raw_i = 1'b0; step(1);
    uv_raw_i = 1'b1; step(UV_DLY - 1); uv_raw_i = 1'b0; step(3);
    chk("R5 uv dropout restarts", status_o, exp_st(6'h01, 0, 0, 0, 0));
    uv_raw_i = 1'b1; step(UV_DLY + 2);
    chk("R6 uv off and psf", status_o, exp_st(6'h00, 0, 0, 0, 1));
    load(16'h2003); step(3);
    chk("R10 set beats clear", status_o, exp_st(6'h00, 0, 0, 0, 1));
    uv_raw_i = 1'b0; step(20);
    chk("R6 recovery psf sticky", status_o, exp_st(6'h01, 0, 0, 0, 1));
    load(16'h2003); step(3);
    chk("R10 clears psf keeps switch", status_o, exp_st(6'h01, 0, 0, 0, 0));

    // R7 open load
    ol_raw_i = 6'b000100; step(OL_DLY + 5); ol_raw_i = '0; step(2);
    chk("R7 off switch ignored", status_o, exp_st(6'h01, 0, 0, 0, 0));
    ol_raw_i = 6'b000001; step(OL_DLY - 1); ol_raw_i = '0; step(2);
    chk("R5 ol short pulse", status_o, exp_st(6'h01, 0, 0, 0, 0));
    ol_raw_i = 6'b000001; step(OL_DLY + 2); ol_raw_i = '0; step(5);
    chk("R7 ol sticky", status_o, exp_st(6'h01, 0, 0, 1, 0));
    load(16'h2003); step(3);
    chk("R10 clears ol", status_o, exp_st(6'h01, 0, 0, 0, 0));

    // R8 overcurrent latch-off
    oc_raw_i = 6'b000001; step(OC_DLY - 1); oc_raw_i = '0; step(1);
    oc_raw_i = 6'b000001; step(OC_DLY - 1); oc_raw_i = '0; step(3);
    chk("R5 oc dropout restarts", status_o, exp_st(6'h01, 0, 0, 0, 0));
    oc_raw_i = 6'b000001; step(OC_DLY + 2); oc_raw_i = '0; step(20);
    chk("R8 latched off", status_o, exp_st(6'h00, 0, 1, 0, 0));
    load(16'h2003); step(20);
    chk("R8 R10 reset re-enables", status_o, exp_st(6'h01, 0, 0, 0, 0));

    // R9 overcurrent flag only
    load(16'h0002); step(20);
    oc_raw_i = 6'b000001; step(OC_DLY + 4); oc_raw_i = '0; step(3);
    chk("R9 flag only", status_o, exp_st(6'h01, 0, 1, 0, 0));
    load(16'h0003); step(3);
    chk("R9 R10 cleared", status_o, exp_st(6'h01, 0, 0, 0, 0));

    // R11 warning follows
    warn_raw_i = 1'b1; step(2);
    chk("R11 warn set", status_o, exp_st(6'h01, 1, 0, 0, 0));
    warn_raw_i = 1'b0; step(2);
    chk("R11 warn not latched", status_o, exp_st(6'h01, 0, 0, 0, 0));

    // R12 thermal shutdown
    load(16'h2002); step(20);
    tsd_raw_i = 1'b1; step(3);
    chk("R12 shutdown off", status_o, exp_st(6'h00, 0, 0, 0, 0));
    tsd_raw_i = 1'b0; step(20);
    chk("R12 cool needs reset", status_o, exp_st(6'h00, 0, 0, 0, 0));
    tsd_raw_i = 1'b1; load(16'h2003); tsd_raw_i = 1'b0; step(20);
    chk("R12 reset while hot ignored", status_o, exp_st(6'h00, 0, 0, 0, 0));
    load(16'h2003); step(20);
    chk("R12 cool plus reset", status_o, exp_st(6'h01, 0, 0, 0, 0));

    // R13 inhibit
    load(16'h0022); step(20);
    oc_raw_i = 6'b010000; step(OC_DLY + 3); oc_raw_i = '0; step(2);
    chk("R13 pre-inhibit", status_o, exp_st(6'h11, 0, 1, 0, 0));
    run_i = 1'b0; step(3);
    chk("R13 standby clears", status_o, 16'h0000);
    run_i = 1'b1; step(20);
    chk("R13 default after restart", status_o, 16'h0000);

    done = 1;
    finish_run();
  end
endmodule